// File: doc/BRIEF.md
# Edge-Triggered Up/Down Event Counter with Input Precedence

This block is an event counter that keeps a count between zero and a programmable ceiling. Every clock cycle is one evaluation interval. Four control levels drive it: a clear, a load-to-ceiling, a count-up and a count-down. Counting reacts only to a 0-to-1 transition of the up or down level; a level that stays high has no further effect. When several controls are active in the same interval, a fixed priority settles which one applies. Clear beats load. Load beats counting. Up beats down, except when the count already sits at the ceiling; in that case the down step is taken instead.

Two registered flags report whether the count is at the ceiling and whether it is at zero. An enable input acts as the block's setting. While enable is low, the counter is held idle: the count is zero, the zero flag is high and the ceiling flag is low. Rising edges that arrive while clear or load is active are used up. They are not applied later when the clear or load is released.

Top module: `evt_counter`

## Requirements
- R1: Each accepted rising edge on `cnt_up` adds one to the count, and each accepted rising edge on `cnt_dn` subtracts one. The new count appears on the clock edge at which the 0-to-1 transition is first sampled, with no extra delay.
- R2: While `clr` is high and `enable` is high, the count becomes 0 on the next clock edge, whatever the state of `ld` and of the count inputs.
- R3: While `ld` is high and `clr` is low, the count becomes the value of `preset` on the next clock edge. Rising edges on `cnt_up` or `cnt_dn` that are sampled while `clr` or `ld` is high are discarded.
- R4: A count input that stays high for several cycles counts once, on its rising edge, and never again until it has gone low.
- R5: A count input that is still high when `clr`, `ld` or `rst` is released is not treated as a new rising edge.
- R6: If rising edges on `cnt_up` and `cnt_dn` are sampled in the same cycle and the count is below `preset`, only the up step is applied.
- R7: If rising edges on `cnt_up` and `cnt_dn` are sampled in the same cycle and the count equals `preset`, the up edge is dropped and the count goes down by one.
- R8: The count saturates. An up edge when the count is at or above `preset` leaves the count unchanged, and a down edge at 0 leaves it at 0.
- R9: While `enable` is low, every control input is ignored: on the next edge the count is 0, `at_zero` is 1 and `at_preset` is 0.
- R10: `at_zero` is 1 exactly when the count is 0. When enabled, `at_preset` is 1 exactly when the count equals the `preset` value sampled on the same clock edge. Both flags are registered together with the count.
- R11: A synchronous active-high `rst` gives count 0, `at_zero` 1 and `at_preset` 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one evaluation interval |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Counter enable setting; low forces the idle state |
| preset | input | CNT_W | Count ceiling |
| clr | input | 1 | Clear count to zero (highest priority) |
| ld | input | 1 | Load count with `preset` |
| cnt_up | input | 1 | Count-up level; acts on its rising edge |
| cnt_dn | input | 1 | Count-down level; acts on its rising edge |
| count | output | CNT_W | Registered count value |
| at_preset | output | 1 | Registered flag: count equals ceiling |
| at_zero | output | 1 | Registered flag: count is zero |

## Verification
The bench builds the block with `CNT_W` = 4 and changes `preset` at run time. A ceiling of 7 exercises the mid-range priority cases. A ceiling of 15 drives the count up to the all-ones code, to show that it saturates and does not wrap. A ceiling of 0 makes the two flags and the two saturation limits coincide. Directed sequences cover the priority and held-level cases. Random control patterns then stress overlapping edges against the reference model.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4,
    OP_OFF   = 3'd5
  } evt_op_t;
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  // Previous level is tracked every cycle, also during reset, clear and
  // load, so a level held across any of them never reads as a new edge.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ch
      always_ff @(posedge clk) begin
        prev_q[g] <= lvl[g];
      end
      assign rise[g] = lvl[g] & ~prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_pkg::*;
(
  input  logic    enable,
  input  logic    clr,
  input  logic    ld,
  input  logic    up_rise,
  input  logic    dn_rise,
  input  logic    at_max,
  output evt_op_t op
);
  always_comb begin
    if (!enable)                 op = OP_OFF;
    else if (clr)                op = OP_CLEAR;
    else if (ld)                 op = OP_LOAD;
    else if (up_rise && dn_rise) op = at_max ? OP_DEC : OP_INC;
    else if (up_rise)            op = OP_INC;
    else if (dn_rise)            op = OP_DEC;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  evt_op_t          op,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             at_preset,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             pre_q, zero_q;

  always_comb begin
    cnt_nxt = cnt_q;
    unique case (op)
      OP_OFF, OP_CLEAR: cnt_nxt = ZERO;
      OP_LOAD:          cnt_nxt = preset;
      OP_INC:           if (cnt_q < preset) cnt_nxt = cnt_q + ONE;
      OP_DEC:           if (cnt_q != ZERO) cnt_nxt = cnt_q - ONE;
      default:          cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= ZERO;
      pre_q  <= 1'b0;
      zero_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      zero_q <= (cnt_nxt == ZERO);
      pre_q  <= (op != OP_OFF) && (cnt_nxt == preset);
    end
  end

  assign count     = cnt_q;
  assign at_preset = pre_q;
  assign at_zero   = zero_q;
endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] preset,
  input  logic             clr,
  input  logic             ld,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  output logic [CNT_W-1:0] count,
  output logic             at_preset,
  output logic             at_zero
);
  localparam int N_CH = 2;

  logic [N_CH-1:0] rise;
  evt_op_t         op;

  evt_edge_det #(.N(N_CH)) u_edge (
    .clk  (clk),
    .lvl  ({cnt_dn, cnt_up}),
    .rise (rise)
  );

  evt_arbiter u_arb (
    .enable  (enable),
    .clr     (clr),
    .ld      (ld),
    .up_rise (rise[0]),
    .dn_rise (rise[1]),
    .at_max  (count == preset),
    .op      (op)
  );

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .preset    (preset),
    .count     (count),
    .at_preset (at_preset),
    .at_zero   (at_zero)
  );
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [CNT_W-1:0] preset,
  input logic             clr,
  input logic             ld,
  input logic             cnt_up,
  input logic             cnt_dn,
  input logic [CNT_W-1:0] count,
  input logic             at_preset,
  input logic             at_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    enable && clr |=> count == '0); // R2

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (rst)
    enable && !clr && ld |=> count == $past(preset)); // R3

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> count == '0 && at_zero && !at_preset); // R9

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    enable && !clr && !ld |=>
      (count == $past(count)) || (count == $past(count) + ONE) ||
      (count == $past(count) - ONE)); // R1

  AST_HELD_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    enable && !clr && !ld && cnt_up && $past(cnt_up) &&
      cnt_dn && $past(cnt_dn) |=> $stable(count)); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    at_zero == (count == '0)); // R10

  AST_PRESET_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(enable) |-> at_preset == (count == $past(preset))); // R10

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> count == '0 && at_zero && !at_preset); // R11
endmodule

bind evt_counter evt_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/evt_counter_tb.sv
module evt_counter_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b1;
  logic [W-1:0] preset = W'(7);
  logic         clr = 1'b0, ld = 1'b0, cnt_up = 1'b0, cnt_dn = 1'b0;
  logic [W-1:0] count;
  logic         at_preset, at_zero;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R11";

  // reference model state
  int m_cnt = 0;
  int m_pz = 0, m_pu = 0;
  bit m_z = 1'b1, m_p = 1'b0;
  bit pu = 1'b0, pd = 1'b0;

  always #2 clk = ~clk;

  evt_counter #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .preset(preset),
    .clr(clr), .ld(ld), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .count(count), .at_preset(at_preset), .at_zero(at_zero)
  );

  always @(posedge clk) begin
    bit ue, de;
    int pv;
    pv = int'(preset);
    ue = cnt_up && !pu;
    de = cnt_dn && !pd;
    if (rst || !enable) begin
      m_cnt = 0;
    end else if (clr) begin
      m_cnt = 0;
    end else if (ld) begin
      m_cnt = pv;
    end else if (ue && de && m_cnt == pv) begin
      if (m_cnt > 0) m_cnt = m_cnt - 1;
    end else if (ue) begin
      if (m_cnt < pv) m_cnt = m_cnt + 1;
    end else if (de) begin
      if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
    m_z = (m_cnt == 0);
    m_p = !rst && enable && (m_cnt == pv);
    pu = cnt_up;
    pd = cnt_dn;
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (int'(count) != m_cnt || at_zero != m_z || at_preset != m_p) begin
        n_fail++;
        $display("FAIL %s model: count=%0d z=%0b p=%0b expected count=%0d z=%0b p=%0b",
                 cur_req, count, at_zero, at_preset, m_cnt, m_z, m_p);
      end
    end
  end

  task automatic chk(input string req, input int exp_cnt, input bit exp_z, input bit exp_p);
    n_chk++;
    if (int'(count) != exp_cnt || at_zero != exp_z || at_preset != exp_p) begin
      n_fail++;
      $display("FAIL %s directed: count=%0d z=%0b p=%0b expected count=%0d z=%0b p=%0b",
               req, count, at_zero, at_preset, exp_cnt, exp_z, exp_p);
    end
  endtask

  task automatic step(input bit c, input bit l, input bit u, input bit d);
    @(negedge clk);
    clr = c; ld = l; cnt_up = u; cnt_dn = d;
  endtask

  task automatic idle();
    step(0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", 0, 1, 0);

    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin step(0, 0, 1, 0); idle(); end
    chk("R1", 3, 0, 0);

    cur_req = "R4";
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0);
    chk("R4", 4, 0, 0);
    idle();

    cur_req = "R6";
    step(0, 0, 1, 1); idle();
    chk("R6", 5, 0, 0);

    cur_req = "R3";
    step(0, 1, 0, 0); idle();
    chk("R3", 7, 0, 1);

    cur_req = "R8";
    step(0, 0, 1, 0); idle();
    chk("R8", 7, 0, 1);

    cur_req = "R7";
    step(0, 0, 1, 1); idle();
    chk("R7", 6, 0, 0);

    cur_req = "R5";
    step(0, 1, 0, 1); step(0, 0, 0, 1); idle();
    chk("R5", 7, 0, 1);

    cur_req = "R2";
    step(1, 1, 0, 0); idle();
    chk("R2", 0, 1, 0);

    cur_req = "R8";
    step(0, 0, 0, 1); idle();
    chk("R8", 0, 1, 0);

    cur_req = "R5";
    step(1, 0, 1, 0); step(0, 0, 1, 0); idle();
    chk("R5", 0, 1, 0);

    cur_req = "R9";
    for (int i = 0; i < 3; i++) begin step(0, 0, 1, 0); idle(); end
    chk("R1", 3, 0, 0);
    @(negedge clk); enable = 1'b0; ld = 1'b1;
    idle();
    chk("R9", 0, 1, 0);
    step(0, 0, 1, 0); idle();
    chk("R9", 0, 1, 0);
    @(negedge clk); enable = 1'b1;
    idle();

    cur_req = "R10";
    preset = W'(15);
    for (int i = 0; i < 17; i++) begin step(0, 0, 1, 0); idle(); end
    chk("R10", 15, 0, 1);
    step(1, 0, 0, 0); idle();
    @(negedge clk); preset = W'(0);
    idle();
    chk("R10", 0, 1, 1);
    step(0, 0, 1, 1); idle();
    chk("R8", 0, 1, 1);

    cur_req = "R1";
    preset = W'(7);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      clr    = ($urandom_range(0, 15) == 0);
      ld     = ($urandom_range(0, 15) == 0);
      cnt_up = $urandom_range(0, 1) == 1;
      cnt_dn = $urandom_range(0, 1) == 1;
      if (i == 300) preset = W'(12);
    end
    idle(); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule